// File: doc/BRIEF.md
# Dual-Rail Erasure-Propagating Column Mixer

This block computes one column of the AES MixColumns step in dual-rail positive logic with a zero spacer. Each logical bit travels as a pair of wires (true rail, false rail). A logical 1 is the pair (1,0), a logical 0 is (0,1), and the precharge or erased state is (0,0). The network uses only monotone AND/OR terms. It is assembled from a dual-rail XOR cell and a dual-rail doubling cell, and contains no inverter.

Because of this, an input pair that is stuck at (0,0), for example after a setup-time violation during evaluation, is never turned into a wrong valid value. Any output bit whose value depends on an erased input is erased too. Output bits that do not depend on it are still computed correctly. The block is purely combinational. The precharge/evaluate sequencing and the registers around it belong to the surrounding datapath.

Top module: `dr_mixcol`

## Requirements
- R1: Bit k of the column is the pair (col_t[k], col_f[k]): (1,0) is logical 1, (0,1) is logical 0, and (0,0) is erased. Byte m occupies bits 8m+7..8m. Output pairs use the same encoding and byte positions.
- R2: When every input pair is valid, output byte i on the true rails equals 02·s(i) ⊕ 03·s(i+1) ⊕ s(i+2) ⊕ s(i+3), with indices taken mod 4. Here 02·a is the byte {a6, a5, a4, a3⊕a7, a2⊕a7, a1, a0⊕a7, a7}, listed from bit 7 down to bit 0, and 03·a = 02·a ⊕ a.
- R3: When every input pair is valid, the false rails of the output are the bitwise complement of the true rails.
- R4: When every input pair is (0,0), every output pair is (0,0).
- R5: With some input pairs erased, an output bit whose logical value does not depend on any erased input bit is valid and equals the value R2 gives for it.
- R6: An output bit whose value depends on at least one erased input bit is (0,0), whatever the other inputs are.
- R7: If every bit of any one input byte is erased, the whole output column is (0,0).
- R8: For inputs in which no pair is (1,1), no output pair is (1,1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| col_t | input | 32 | True rails of the four input bytes |
| col_f | input | 32 | False rails of the four input bytes |
| mix_t | output | 32 | True rails of the four mixed output bytes |
| mix_f | output | 32 | False rails of the four mixed output bytes |

## Verification
Within a single evaluation, the block both computes valid bits and erases others, so two output bits of the same column can be in different regimes at once. The bench provokes this with sparse random erasure masks laid over random column values. It derives each output bit's dependency set from the linearity of the mix, by applying it to single-bit unit inputs. Each bit is then judged on its own: it must be the correct valid value when its dependency set avoids the erased inputs, and (0,0) otherwise.

// File: rtl/dr_pkg.sv
package dr_pkg;
    localparam int BYTE_W    = 8;
    localparam int COL_BYTES = 4;
    localparam int COL_W     = BYTE_W * COL_BYTES;

    typedef struct packed {
        logic [BYTE_W-1:0] t;
        logic [BYTE_W-1:0] f;
    } dr_byte_t;
endpackage

// File: rtl/dr_xor2.sv
// Bitwise dual-rail XOR built only from AND/OR terms.
module dr_xor2 #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_t,
    input  logic [W-1:0] a_f,
    input  logic [W-1:0] b_t,
    input  logic [W-1:0] b_f,
    output logic [W-1:0] y_t,
    output logic [W-1:0] y_f
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y_t[i] = (a_t[i] & b_f[i]) | (a_f[i] & b_t[i]);
        assign y_f[i] = (a_f[i] | b_t[i]) & (a_t[i] | b_f[i]);
    end
endmodule

// File: rtl/dr_xtime.sv
// Dual-rail multiply by 02 in GF(2^8); only bits 4, 3 and 1 need a XOR.
module dr_xtime
    import dr_pkg::*;
(
    input  dr_byte_t x,
    output dr_byte_t y
);
    localparam int NX = 3;
    logic [NX-1:0] lo_t, lo_f, hi_t, hi_f, r_t, r_f;

    assign lo_t = {x.t[3], x.t[2], x.t[0]};
    assign lo_f = {x.f[3], x.f[2], x.f[0]};
    assign hi_t = {NX{x.t[7]}};
    assign hi_f = {NX{x.f[7]}};

    dr_xor2 #(.W(NX)) u_fold (
        .a_t(lo_t), .a_f(lo_f), .b_t(hi_t), .b_f(hi_f),
        .y_t(r_t),  .y_f(r_f)
    );

    assign y.t = {x.t[6], x.t[5], x.t[4], r_t[2], r_t[1], x.t[1], r_t[0], x.t[7]};
    assign y.f = {x.f[6], x.f[5], x.f[4], r_f[2], r_f[1], x.f[1], r_f[0], x.f[7]};
endmodule

// File: rtl/dr_mix_lane.sv
// One output byte: 02*s0 ^ 03*s1 ^ s2 ^ s3, as 02*s0 ^ 02*s1 ^ s1 ^ s2 ^ s3.
module dr_mix_lane
    import dr_pkg::*;
(
    input  dr_byte_t s0,
    input  dr_byte_t s1,
    input  dr_byte_t s2,
    input  dr_byte_t s3,
    output dr_byte_t y
);
    dr_byte_t d0, d1, p, q, r;

    dr_xtime u_dbl0 (.x(s0), .y(d0));
    dr_xtime u_dbl1 (.x(s1), .y(d1));

    dr_xor2 #(.W(BYTE_W)) u_x_p (
        .a_t(d0.t), .a_f(d0.f), .b_t(d1.t), .b_f(d1.f), .y_t(p.t), .y_f(p.f)
    );
    dr_xor2 #(.W(BYTE_W)) u_x_q (
        .a_t(s1.t), .a_f(s1.f), .b_t(s2.t), .b_f(s2.f), .y_t(q.t), .y_f(q.f)
    );
    dr_xor2 #(.W(BYTE_W)) u_x_r (
        .a_t(p.t), .a_f(p.f), .b_t(q.t), .b_f(q.f), .y_t(r.t), .y_f(r.f)
    );
    dr_xor2 #(.W(BYTE_W)) u_x_y (
        .a_t(r.t), .a_f(r.f), .b_t(s3.t), .b_f(s3.f), .y_t(y.t), .y_f(y.f)
    );
endmodule

// File: rtl/dr_mixcol.sv
module dr_mixcol
    import dr_pkg::*;
(
    input  logic [31:0] col_t,
    input  logic [31:0] col_f,
    output logic [31:0] mix_t,
    output logic [31:0] mix_f
);
    dr_byte_t in_b  [COL_BYTES];
    dr_byte_t out_b [COL_BYTES];

    for (genvar m = 0; m < COL_BYTES; m++) begin : g_lane
        assign in_b[m].t = col_t[m*BYTE_W +: BYTE_W];
        assign in_b[m].f = col_f[m*BYTE_W +: BYTE_W];

        dr_mix_lane u_lane (
            .s0(in_b[m]),
            .s1(in_b[(m+1) % COL_BYTES]),
            .s2(in_b[(m+2) % COL_BYTES]),
            .s3(in_b[(m+3) % COL_BYTES]),
            .y (out_b[m])
        );

        assign mix_t[m*BYTE_W +: BYTE_W] = out_b[m].t;
        assign mix_f[m*BYTE_W +: BYTE_W] = out_b[m].f;
    end
endmodule

// File: rtl/dr_mixcol_chk.sv
module dr_mixcol_chk (
    input logic [31:0] col_t,
    input logic [31:0] col_f,
    input logic [31:0] mix_t,
    input logic [31:0] mix_f
);
    logic known;
    logic any_byte_erased;

    always_comb begin
        known = !$isunknown({col_t, col_f, mix_t, mix_f});
        any_byte_erased = 1'b0;
        for (int m = 0; m < 4; m++)
            if ((col_t[m*8 +: 8] | col_f[m*8 +: 8]) == 8'h00) any_byte_erased = 1'b1;
    end

    always_comb begin
        if (known) begin
            AST_PRECHARGE_IDLE: assert (!((col_t | col_f) == 32'h0) || ((mix_t | mix_f) == 32'h0)); // R4
            AST_RAILS_COMPLEMENT: assert (!((col_t ^ col_f) == 32'hFFFF_FFFF) || (mix_t == ~mix_f)); // R3
            AST_BYTE_ERASE_SPREADS: assert (!any_byte_erased || ((mix_t | mix_f) == 32'h0)); // R7
            AST_NO_DOUBLE_HIGH: assert (!((col_t & col_f) == 32'h0) || ((mix_t & mix_f) == 32'h0)); // R8
        end
    end
endmodule

bind dr_mixcol dr_mixcol_chk u_chk (
    .col_t(col_t), .col_f(col_f), .mix_t(mix_t), .mix_f(mix_f)
);

// File: tb/dr_mixcol_test.sv
module dr_mixcol_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] col_t, col_f, mix_t, mix_f;
    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] dep [32];

    always #5 clk = ~clk;

    dr_mixcol uut (.col_t(col_t), .col_f(col_f), .mix_t(mix_t), .mix_f(mix_f));

    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [31:0] ref_mix(input logic [31:0] c);
        logic [7:0] s [4];
        logic [31:0] o;
        for (int m = 0; m < 4; m++) s[m] = c[m*8 +: 8];
        for (int i = 0; i < 4; i++)
            o[i*8 +: 8] = xt(s[i]) ^ xt(s[(i+1)%4]) ^ s[(i+1)%4] ^ s[(i+2)%4] ^ s[(i+3)%4];
        return o;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Drive value v with erased bits in mask nul, then judge every output bit.
    task automatic apply(input logic [31:0] v, input logic [31:0] nul);
        logic [31:0] r, ok, et, ef;
        @(negedge clk);
        col_t = v & ~nul;
        col_f = ~v & ~nul;
        #1;
        r = ref_mix(v);
        ok = 32'h0;
        for (int o = 0; o < 32; o++) ok[o] = ((dep[o] & nul) == 32'h0);
        et = r & ok;
        ef = ~r & ok;
        if (nul == 32'h0) begin
            chk("R2 true rails", mix_t, r);
            chk("R3 false rails", mix_f, ~r);
        end else begin
            chk("R5 valid bits", {mix_t & ok}, et);
            chk("R5 valid bits false rail", {mix_f & ok}, ef);
            chk("R6 erased bits", {(mix_t | mix_f) & ~ok}, 32'h0);
        end
        chk("R8 no double high", mix_t & mix_f, 32'h0);
    endtask

    initial begin
        col_t = '0;
        col_f = '0;
        for (int k = 0; k < 32; k++) dep[k] = '0;
        for (int k = 0; k < 32; k++) begin
            logic [31:0] u;
            u = ref_mix(32'h1 << k);
            for (int o = 0; o < 32; o++) if (u[o]) dep[o][k] = 1'b1;
        end
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R4: precharge column gives precharge outputs
        @(negedge clk);
        #1;
        chk("R4 precharge true", mix_t, 32'h0);
        chk("R4 precharge false", mix_f, 32'h0);

        // R1 R2: known column db 13 53 45 -> 8e 4d a1 bc, byte 0 in low bits
        apply(32'h4553_13DB, 32'h0);
        chk("R1 R2 known vector", mix_t, 32'hBCA1_4D8E);
        apply(32'h0000_0000, 32'h0);
        apply(32'hFFFF_FFFF, 32'h0);
        apply(32'h8080_8080, 32'h0);

        // R5 R6: single erased bits including bit 7 of a byte (feeds the fold)
        apply(32'h4553_13DB, 32'h0000_0080);
        apply(32'h4553_13DB, 32'h0001_0000);
        apply(32'hA5C3_0F96, 32'h8000_0000);

        // R7: a whole byte erased wipes the column
        for (int m = 0; m < 4; m++) begin
            apply(32'h1234_5678 ^ (m * 32'h1111_1111), 32'hFF << (m*8));
            chk("R7 byte erased true", mix_t, 32'h0);
            chk("R7 byte erased false", mix_f, 32'h0);
        end

        // Random mix: clean columns and sparse erasure masks
        void'($urandom(32'd7193));
        for (int i = 0; i < 400; i++) begin
            logic [31:0] v, n;
            v = $urandom;
            case (i % 3)
                0: n = 32'h0;
                1: n = 32'h1 << ($urandom % 32);
                default: n = $urandom & $urandom & $urandom;
            endcase
            apply(v, n);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule